// File: doc/BRIEF.md
# Debug Trigger Condition Sequencer

This block watches the CPU bus one cycle at a time and decides when a debug run has reached its trigger condition. Two address comparators, A and B, each check the bus address against a programmed value, and each can also be made to match only on reads or only on writes. A 4-bit mode selector combines the two comparator results into one trigger condition. The modes are A alone, A or B, and an ordered A-then-B sequence.

A run starts with an arm request. Arming clears the per-run hit flags. The run ends on the first trigger, or earlier when software disarms the unit or drops its enable. When opcode gating is selected, a comparator hit on an opcode fetch is held in a small in-order tracking queue. It counts only when the CPU reports that this opcode was executed. A change-of-flow flush throws away every pending fetch. On the trigger cycle the block can also raise a CPU breakpoint request, either as a tag request or as a force request.

Top module: `dbg_trig_seq`

## Requirements
- R1: The mode codes are 0 (A only), 1 (A or B) and 2 (A then B). Codes 3 to 15 never trigger and leave the run armed.
- R2: In mode 0, a qualified comparator A hit while armed causes a trigger.
- R3: In mode 1, a qualified hit on either comparator while armed causes a trigger.
- R4: In mode 2, a B hit triggers only if an A hit occurred in an earlier cycle of the same run. Any number of idle cycles may lie between the two hits. A B hit in the same cycle as the first A hit does not complete the sequence.
- R5: When a comparator's R/W qualify bit is 1, the comparator hits only if bus_read_i equals its level bit (1 = read, 0 = write). When the qualify bit is 0, the direction is ignored.
- R6: With op_sel_i = 1, only cycles with bus_fetch_i = 1 are recorded, in fetch order. A recorded hit counts in the cycle that exec_i retires that fetch. Hits on non-fetch cycles never count.
- R7: flush_i discards every pending fetch, so a later exec_i produces no hit from them.
- R8: After reset, every output is 0. An arm request (with enable high) sets armed_o and clears a_hit_o and b_hit_o. Disarm, or enable low, clears armed_o and has priority over arm.
- R9: trig_o is a one-cycle pulse in the cycle after the qualifying bus cycle. It clears armed_o at the same edge. No trigger is produced while the unit is not armed.
- R10: With brk_en_i = 1, the trigger cycle also raises brk_tag_o (if brk_tag_i = 1) or brk_force_o (if brk_tag_i = 0). With brk_en_i = 0, neither is raised.
- R11: a_hit_o and b_hit_o record the qualified hits seen while armed. They hold their value after the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Unit enable; low stops any run |
| arm_i | input | 1 | Arm request pulse |
| disarm_i | input | 1 | Disarm request pulse |
| mode_i | input | 4 | Trigger mode code |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_read_i | input | 1 | 1 = read cycle, 0 = write |
| bus_fetch_i | input | 1 | Cycle is an opcode fetch |
| exec_i | input | 1 | Oldest fetched opcode executed |
| flush_i | input | 1 | Change-of-flow flush of pending fetches |
| cmp_a_i | input | ADDR_W | Comparator A value |
| cmp_b_i | input | ADDR_W | Comparator B value |
| rw_qual_a_i | input | 1 | Enable R/W qualification on A |
| rw_lvl_a_i | input | 1 | Required bus_read_i level for A |
| rw_qual_b_i | input | 1 | Enable R/W qualification on B |
| rw_lvl_b_i | input | 1 | Required bus_read_i level for B |
| op_sel_i | input | 1 | Gate hits through opcode tracking |
| brk_en_i | input | 1 | Breakpoint request enable |
| brk_tag_i | input | 1 | 1 = tag request, 0 = force request |
| armed_o | output | 1 | Run in progress |
| a_hit_o | output | 1 | Comparator A hit seen in this run |
| b_hit_o | output | 1 | Comparator B hit seen in this run |
| trig_o | output | 1 | Trigger pulse |
| brk_tag_o | output | 1 | Tag breakpoint request |
| brk_force_o | output | 1 | Force breakpoint request |

## Verification
Several properties are checked on every cycle:
- the trigger is a single pulse that always follows an armed cycle and ends the run;
- an arm request clears the flags, and disarm or enable low stops the run;
- an A-then-B trigger was preceded by a recorded A hit;
- the breakpoint lines are mutually exclusive and appear only with a trigger;
- the tracking queue empties on a flush and drains by one entry on each retire.

Only the directed scenarios can show the rest:
- which mode codes trigger on which address patterns;
- that R/W qualification rejects the wrong direction;
- that fetched hits wait for retirement in program order;
- that a flushed fetch never fires.

// File: rtl/dbg_trig_pkg.sv
`timescale 1ns/1ps
package dbg_trig_pkg;
   localparam logic [3:0] MODE_A_ONLY   = 4'd0;
   localparam logic [3:0] MODE_A_OR_B   = 4'd1;
   localparam logic [3:0] MODE_A_THEN_B = 4'd2;

   typedef struct packed {
      logic a;
      logic b;
   } hit_pair_t;
endpackage

// File: rtl/dbg_addr_cmp.sv
`timescale 1ns/1ps
module dbg_addr_cmp #(
   parameter int ADDR_W = 16
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              read_i,
   input  logic [ADDR_W-1:0] ref_i,
   input  logic              rw_qual_i,
   input  logic              rw_lvl_i,
   output logic              hit_o
);
   logic addr_eq, dir_ok;

   assign addr_eq = (addr_i == ref_i);
   assign dir_ok  = ~rw_qual_i | (read_i == rw_lvl_i);
   assign hit_o   = valid_i & addr_eq & dir_ok;
endmodule

// File: rtl/dbg_op_track.sv
`timescale 1ns/1ps
module dbg_op_track
   import dbg_trig_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push_i,
   input  hit_pair_t tag_i,
   input  logic      pop_i,
   input  logic      flush_i,
   output hit_pair_t ev_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   hit_pair_t         slot_q [DEPTH];
   logic [PW-1:0]     rd_q, wr_q;
   logic [CW-1:0]     cnt_q;
   logic              empty, full, do_pop, do_push;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign do_pop  = pop_i & ~empty & ~flush_i;
   assign do_push = push_i & ~flush_i & (~full | do_pop);
   assign ev_o    = do_pop ? slot_q[rd_q] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (flush_i) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) begin
            slot_q[wr_q] <= tag_i;
            wr_q         <= bump(wr_q);
         end
         if (do_pop) rd_q <= bump(rd_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cnt_q == '0));

   a_r6_retire_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !flush_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dbg_trig_ctl.sv
`timescale 1ns/1ps
module dbg_trig_ctl
   import dbg_trig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       arm_i,
   input  logic       disarm_i,
   input  logic [3:0] mode_i,
   input  logic       qa_i,
   input  logic       qb_i,
   input  logic       brk_en_i,
   input  logic       brk_tag_i,
   output logic       armed_o,
   output logic       af_o,
   output logic       bf_o,
   output logic       trig_o,
   output logic       brk_tag_o,
   output logic       brk_force_o
);
   logic armed_q, af_q, bf_q, trig_q, btag_q, bforce_q;
   logic cond, live, fire;

   always_comb begin
      case (mode_i)
         MODE_A_ONLY:   cond = qa_i;
         MODE_A_OR_B:   cond = qa_i | qb_i;
         MODE_A_THEN_B: cond = qb_i & af_q;
         default:       cond = 1'b0;
      endcase
   end

   assign live = en_i & armed_q & ~disarm_i & ~arm_i;
   assign fire = live & cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         af_q     <= 1'b0;
         bf_q     <= 1'b0;
         trig_q   <= 1'b0;
         btag_q   <= 1'b0;
         bforce_q <= 1'b0;
      end else begin
         trig_q   <= fire;
         btag_q   <= fire & brk_en_i & brk_tag_i;
         bforce_q <= fire & brk_en_i & ~brk_tag_i;
         if (!en_i || disarm_i) begin
            armed_q <= 1'b0;
         end else if (arm_i) begin
            armed_q <= 1'b1;
            af_q    <= 1'b0;
            bf_q    <= 1'b0;
         end else if (armed_q) begin
            af_q <= af_q | qa_i;
            bf_q <= bf_q | qb_i;
            if (cond) armed_q <= 1'b0;
         end
      end
   end

   assign armed_o     = armed_q;
   assign af_o        = af_q;
   assign bf_o        = bf_q;
   assign trig_o      = trig_q;
   assign brk_tag_o   = btag_q;
   assign brk_force_o = bforce_q;

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |=> !trig_q);
   a_r9_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |-> $past(armed_q));
   a_r9_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |-> !armed_q);
   a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && en_i && !disarm_i) |=> (armed_q && !af_q && !bf_q));
   a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || disarm_i) |=> !armed_q);
   a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q && $past(mode_i) == MODE_A_THEN_B) |-> $past(af_q));
   a_r10_brk_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(btag_q && bforce_q));
   a_r10_brk_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (btag_q || bforce_q) |-> trig_q);
endmodule

// File: rtl/dbg_trig_seq.sv
`timescale 1ns/1ps
module dbg_trig_seq
   import dbg_trig_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int TRK_DEPTH = 4,
   parameter bit USE_TRACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              arm_i,
   input  logic              disarm_i,
   input  logic [3:0]        mode_i,
   input  logic              bus_valid_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_read_i,
   input  logic              bus_fetch_i,
   input  logic              exec_i,
   input  logic              flush_i,
   input  logic [ADDR_W-1:0] cmp_a_i,
   input  logic [ADDR_W-1:0] cmp_b_i,
   input  logic              rw_qual_a_i,
   input  logic              rw_lvl_a_i,
   input  logic              rw_qual_b_i,
   input  logic              rw_lvl_b_i,
   input  logic              op_sel_i,
   input  logic              brk_en_i,
   input  logic              brk_tag_i,
   output logic              armed_o,
   output logic              a_hit_o,
   output logic              b_hit_o,
   output logic              trig_o,
   output logic              brk_tag_o,
   output logic              brk_force_o
);
   localparam int NCMP = 2;

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_aw
      $error("dbg_trig_seq: ADDR_W must lie in 2..64");
   end
   if (TRK_DEPTH < 2 || TRK_DEPTH > 64) begin : g_bad_depth
      $error("dbg_trig_seq: TRK_DEPTH must lie in 2..64");
   end

   logic [ADDR_W-1:0] ref_w  [NCMP];
   logic              qual_w [NCMP];
   logic              lvl_w  [NCMP];
   logic [NCMP-1:0]   raw_hit;
   hit_pair_t         raw_pair, qual_pair;

   assign ref_w[0]  = cmp_a_i;
   assign ref_w[1]  = cmp_b_i;
   assign qual_w[0] = rw_qual_a_i;
   assign qual_w[1] = rw_qual_b_i;
   assign lvl_w[0]  = rw_lvl_a_i;
   assign lvl_w[1]  = rw_lvl_b_i;

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      dbg_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
         .valid_i   (bus_valid_i),
         .addr_i    (bus_addr_i),
         .read_i    (bus_read_i),
         .ref_i     (ref_w[k]),
         .rw_qual_i (qual_w[k]),
         .rw_lvl_i  (lvl_w[k]),
         .hit_o     (raw_hit[k])
      );
   end

   assign raw_pair.a = raw_hit[0];
   assign raw_pair.b = raw_hit[1];

   if (USE_TRACK) begin : g_track
      hit_pair_t ev;
      dbg_op_track #(.DEPTH(TRK_DEPTH)) trk_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .push_i  (op_sel_i & bus_valid_i & bus_fetch_i),
         .tag_i   (raw_pair),
         .pop_i   (exec_i),
         .flush_i (flush_i | ~op_sel_i),
         .ev_o    (ev)
      );
      assign qual_pair = op_sel_i ? ev : raw_pair;
   end else begin : g_direct
      assign qual_pair = raw_pair;
   end

   dbg_trig_ctl ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (enable_i),
      .arm_i       (arm_i),
      .disarm_i    (disarm_i),
      .mode_i      (mode_i),
      .qa_i        (qual_pair.a),
      .qb_i        (qual_pair.b),
      .brk_en_i    (brk_en_i),
      .brk_tag_i   (brk_tag_i),
      .armed_o     (armed_o),
      .af_o        (a_hit_o),
      .bf_o        (b_hit_o),
      .trig_o      (trig_o),
      .brk_tag_o   (brk_tag_o),
      .brk_force_o (brk_force_o)
   );
endmodule

// File: tb/dbg_trig_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_seq_tb_top;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable_i = 1'b0, arm_i = 1'b0, disarm_i = 1'b0;
   logic [3:0] mode_i = 4'd0;
   logic bus_valid_i = 1'b0, bus_read_i = 1'b1, bus_fetch_i = 1'b0;
   logic [AW-1:0] bus_addr_i = '0;
   logic exec_i = 1'b0, flush_i = 1'b0;
   logic [AW-1:0] cmp_a_i = '0, cmp_b_i = '0;
   logic rw_qual_a_i = 1'b0, rw_lvl_a_i = 1'b0, rw_qual_b_i = 1'b0, rw_lvl_b_i = 1'b0;
   logic op_sel_i = 1'b0, brk_en_i = 1'b0, brk_tag_i = 1'b0;
   logic armed_o, a_hit_o, b_hit_o, trig_o, brk_tag_o, brk_force_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dbg_trig_seq #(.ADDR_W(AW), .TRK_DEPTH(4), .USE_TRACK(1'b1)) dut_i (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic arm();
      arm_i = 1'b1;
      tick();
      arm_i = 1'b0;
   endtask

   task automatic bus(input logic [AW-1:0] a, input logic rd, input logic fe);
      bus_valid_i = 1'b1;
      bus_addr_i  = a;
      bus_read_i  = rd;
      bus_fetch_i = fe;
      tick();
      bus_valid_i = 1'b0;
      bus_fetch_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R8", "reset armed", armed_o, 0);
      chk("R8", "reset trig", trig_o, 0);
      chk("R8", "reset flags", {a_hit_o, b_hit_o, brk_tag_o, brk_force_o}, 0);
   endtask

   task automatic t_a_only();
      mode_i = 4'd0; cmp_a_i = 16'h1234; cmp_b_i = 16'h0999;
      arm();
      chk("R8", "armed after arm", armed_o, 1);
      bus(16'h1000, 1'b1, 1'b0);
      chk("R2", "no hit no trig", trig_o, 0);
      bus(16'h1234, 1'b1, 1'b0);
      chk("R2", "A hit trig", trig_o, 1);
      chk("R9", "run ends", armed_o, 0);
      chk("R11", "a flag", a_hit_o, 1);
      tick();
      chk("R9", "pulse one cycle", trig_o, 0);
      bus(16'h1234, 1'b1, 1'b0);
      chk("R9", "no trig disarmed", trig_o, 0);
      chk("R11", "a flag holds", a_hit_o, 1);
      arm();
      chk("R8", "arm clears flags", {a_hit_o, b_hit_o}, 0);
      disarm_i = 1'b1; tick(); disarm_i = 1'b0;
   endtask

   task automatic t_a_or_b();
      mode_i = 4'd1; cmp_a_i = 16'h0010; cmp_b_i = 16'h0020;
      arm();
      bus(16'h0020, 1'b0, 1'b0);
      chk("R3", "B trig", trig_o, 1);
      chk("R11", "flags after B", {a_hit_o, b_hit_o}, 1);
      arm();
      bus(16'h0010, 1'b1, 1'b0);
      chk("R3", "A trig", trig_o, 1);
      chk("R11", "flags after A", {a_hit_o, b_hit_o}, 2);
   endtask

   task automatic t_a_then_b();
      mode_i = 4'd2; cmp_a_i = 16'h0010; cmp_b_i = 16'h0020;
      arm();
      bus(16'h0020, 1'b1, 1'b0);
      chk("R4", "B before A", trig_o, 0);
      bus(16'h0010, 1'b1, 1'b0);
      chk("R4", "A alone", trig_o, 0);
      for (int i = 0; i < 5; i++) tick();
      bus(16'h0020, 1'b1, 1'b0);
      chk("R4", "B after A", trig_o, 1);
      cmp_a_i = 16'h0030; cmp_b_i = 16'h0030;
      arm();
      bus(16'h0030, 1'b1, 1'b0);
      chk("R4", "same cycle A B", trig_o, 0);
      chk("R4", "still armed", armed_o, 1);
      bus(16'h0030, 1'b1, 1'b0);
      chk("R4", "next B trig", trig_o, 1);
   endtask

   task automatic t_rw();
      mode_i = 4'd0; cmp_a_i = 16'h0040; rw_qual_a_i = 1'b1; rw_lvl_a_i = 1'b0;
      arm();
      bus(16'h0040, 1'b1, 1'b0);
      chk("R5", "read rejected", {trig_o, a_hit_o}, 0);
      bus(16'h0040, 1'b0, 1'b0);
      chk("R5", "write accepted", trig_o, 1);
      rw_qual_a_i = 1'b0;
   endtask

   task automatic t_track();
      mode_i = 4'd0; cmp_a_i = 16'h0050; op_sel_i = 1'b1;
      tick();
      arm();
      bus(16'h0060, 1'b1, 1'b1);
      bus(16'h0050, 1'b1, 1'b1);
      chk("R6", "fetch waits", trig_o, 0);
      bus(16'h0050, 1'b1, 1'b0);
      chk("R6", "data cycle ignored", trig_o, 0);
      exec_i = 1'b1; tick();
      chk("R6", "older fetch retires", trig_o, 0);
      tick(); exec_i = 1'b0;
      chk("R6", "match retires", trig_o, 1);
      arm();
      bus(16'h0050, 1'b1, 1'b1);
      flush_i = 1'b1; tick(); flush_i = 1'b0;
      exec_i = 1'b1; tick(); exec_i = 1'b0;
      chk("R7", "flushed no trig", trig_o, 0);
      chk("R7", "still armed", armed_o, 1);
      disarm_i = 1'b1; tick(); disarm_i = 1'b0;
      op_sel_i = 1'b0;
   endtask

   task automatic t_modes_off();
      cmp_a_i = 16'h0070; cmp_b_i = 16'h0071;
      mode_i = 4'd3;
      arm();
      bus(16'h0070, 1'b1, 1'b0);
      bus(16'h0071, 1'b1, 1'b0);
      chk("R1", "mode 3 no trig", trig_o, 0);
      mode_i = 4'd15;
      bus(16'h0070, 1'b1, 1'b0);
      chk("R1", "mode 15 no trig", trig_o, 0);
      chk("R1", "still armed", armed_o, 1);
      mode_i = 4'd0;
      disarm_i = 1'b1; tick(); disarm_i = 1'b0;
   endtask

   task automatic t_stop();
      mode_i = 4'd0; cmp_a_i = 16'h0080;
      arm();
      disarm_i = 1'b1; tick(); disarm_i = 1'b0;
      chk("R8", "disarm", armed_o, 0);
      bus(16'h0080, 1'b1, 1'b0);
      chk("R8", "no trig after disarm", trig_o, 0);
      arm();
      enable_i = 1'b0; tick(); enable_i = 1'b1;
      chk("R8", "enable low stops", armed_o, 0);
      arm_i = 1'b1; disarm_i = 1'b1; tick(); arm_i = 1'b0; disarm_i = 1'b0;
      chk("R8", "disarm beats arm", armed_o, 0);
   endtask

   task automatic t_brk();
      mode_i = 4'd0; cmp_a_i = 16'h0090; brk_en_i = 1'b1; brk_tag_i = 1'b1;
      arm(); bus(16'h0090, 1'b1, 1'b0);
      chk("R10", "tag req", {brk_tag_o, brk_force_o}, 2);
      brk_tag_i = 1'b0;
      arm(); bus(16'h0090, 1'b1, 1'b0);
      chk("R10", "force req", {brk_tag_o, brk_force_o}, 1);
      brk_en_i = 1'b0;
      arm(); bus(16'h0090, 1'b1, 1'b0);
      chk("R10", "trig without brk", trig_o, 1);
      chk("R10", "brk off", {brk_tag_o, brk_force_o}, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog all-R actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick();
      tick();
      t_reset();
      rst_n = 1'b1;
      enable_i = 1'b1;
      tick();
      t_a_only();
      t_a_or_b();
      t_a_then_b();
      t_rw();
      t_track();
      t_modes_off();
      t_stop();
      t_brk();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule